// File: doc/BRIEF.md
# Code-Region Bus Access Filter

This block sits in front of the memory map and decides, one access at a time, whether a bus request may proceed. Code space is non-volatile memory. A length value splits it into a low part, code region 0, and a high part, code region 1. Every request carries the address of the instruction that issued it, and that address gives the source region. The target address is sorted into one of four spaces: region 0 code, region 1 code, RAM, or other space. Code that runs from region 0 may touch everything. Code that runs from region 1 can always read and fetch. Its writes into region 0 code and into RAM are each allowed only if the matching policy bit grants full access. If the bit is clear, access there is read-only.

The block also holds a bitmap with one write-protect bit per non-volatile sector. A bit can only be set. A soft reset clears all of them. A write that falls in a protected sector is refused, whatever its source. A refused access never reaches memory. In silent mode, a refused read returns zero and a refused write is dropped. In hard mode, a one-cycle fault pulse reports the address and access kind.

The control state machine has four states. UNCFG waits after hard reset for the one-time policy load. IDLE holds no response. GRANT drives a memory access and a response. DENY drives a response with no memory access. The transitions are:
- load: UNCFG to IDLE on `cfg_load`.
- accept: IDLE, GRANT or DENY to GRANT when the accepted request is permitted.
- refuse: IDLE, GRANT or DENY to DENY when the accepted request is not permitted.
- drain: GRANT or DENY to IDLE when no request is present.

A hard reset returns the machine to UNCFG from any state.

Top module: `code_region_guard`

## Requirements
- R1: After hard reset, `req_ready`, `rsp_valid`, `mem_en` and `fault_valid` are low. `req_ready` rises in the cycle after `cfg_load` and stays high until the next hard reset.
- R2: A request whose `req_pc` is below both the loaded length and the end of non-volatile memory (64 sectors of 256 bytes, addresses below 0x4000) is granted for every kind and target, unless it is a write to a protected sector.
- R3: A read (kind 0) or fetch (kind 2) from any other `req_pc` is granted for every target.
- R4: A write (kind 1) from region 1 to an address below the length is granted only when the latched `cfg_r1_code_rw` is 1.
- R5: A write from region 1 to RAM (0x8000 to 0x9FFF) is granted only when the latched `cfg_r1_ram_rw` is 1.
- R6: A write from region 1 to region 1 code (from the length up to 0x3FFF) or to other space is granted, unless the sector is protected.
- R7: A write to a non-volatile address whose sector bit (index = address / 256) is set is refused for any source. Reads and fetches of that address are still granted.
- R8: `lock_set` ORs `lock_mask` into the sector bits, so bits are never cleared by it. `soft_rst` clears all bits and takes priority over a `lock_set` in the same cycle.
- R9: A refused access keeps `mem_en` low and returns `rsp_rdata` of zero, so a refused write leaves memory unchanged.
- R10: When the latched `cfg_hard_fault` is 1, each refused access raises `fault_valid` for its response cycle, with `fault_addr` set to its address and `fault_kind` set to its kind. When the bit is 0, `fault_valid` stays low.
- R11: An accepted request gives `rsp_valid` exactly one cycle later. A granted request drives `mem_en`, `mem_we` (set for kind 1), `mem_addr` and `mem_wdata` in that cycle. A granted read returns `mem_rdata`, and a granted write returns zero.
- R12: A `cfg_load` after the first one is ignored, so the first length and policy bits stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset; clears sector protection |
| cfg_load | input | 1 | One-time policy load strobe |
| cfg_len | input | ADDR_W | Length of code region 0 in bytes |
| cfg_r1_code_rw | input | 1 | Region 1 may write region 0 code |
| cfg_r1_ram_rw | input | 1 | Region 1 may write RAM |
| cfg_hard_fault | input | 1 | 1 selects the fault pulse, 0 silent refusal |
| lock_set | input | 1 | Strobe to set sector protection bits |
| lock_mask | input | SECTORS | Sector bits to set |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Requests are accepted |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_pc | input | ADDR_W | Address of the issuing instruction |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | DATA_W | Read data or zero |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_addr | output | ADDR_W | Faulting address |
| fault_kind | output | 2 | Faulting access kind |

## Verification
The hardest case to reach is a soft reset that lands in the same cycle as a sector set, while a write to that sector follows at once. The bench drives exactly that pattern. It then writes the sector from region 0 and reads it back.

A silent refusal shows nothing on the fault port. Its only trace is missing memory traffic. The bench therefore checks `mem_en` in every response cycle, and reads each address back after a refused write to that address.

A second configuration load is only visible through a later decision. The bench sends a region 1 write whose target class depends on which length is in force.

// File: rtl/crg_pkg.sv
package crg_pkg;

    typedef enum logic [1:0] {
        TGT_CODE0 = 2'd0,
        TGT_CODE1 = 2'd1,
        TGT_RAM   = 2'd2,
        TGT_OTHER = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_IDLE  = 2'd1,
        ST_GRANT = 2'd2,
        ST_DENY  = 2'd3
    } state_e;

    typedef struct packed {
        logic r1_code_rw;
        logic r1_ram_rw;
        logic hard;
    } policy_t;

endpackage

// File: rtl/crg_decode.sv
module crg_decode
    import crg_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int SECTORS      = 64,
    parameter int SECTOR_BYTES = 256,
    parameter int RAM_BASE     = 32'h8000,
    parameter int RAM_BYTES    = 32'h2000
)(
    input  logic [ADDR_W-1:0]          len,
    input  logic [ADDR_W-1:0]          pc,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       src_r0,
    output tgt_e                       tgt,
    output logic                       in_nvm,
    output logic [$clog2(SECTORS)-1:0] sec_idx
);
    localparam int SEC_SHIFT = $clog2(SECTOR_BYTES);
    localparam int SEC_IDX_W = $clog2(SECTORS);
    localparam logic [ADDR_W:0] NVM_LIM = (ADDR_W+1)'(SECTORS * SECTOR_BYTES);
    localparam logic [ADDR_W:0] RAM_LO  = (ADDR_W+1)'(RAM_BASE);
    localparam logic [ADDR_W:0] RAM_HI  = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

    logic [ADDR_W:0] pc_x, addr_x, len_x;

    always_comb begin
        pc_x    = {1'b0, pc};
        addr_x  = {1'b0, addr};
        len_x   = {1'b0, len};
        src_r0  = (pc_x < NVM_LIM) && (pc_x < len_x);
        in_nvm  = addr_x < NVM_LIM;
        sec_idx = addr[SEC_SHIFT +: SEC_IDX_W];
        if (in_nvm) begin
            tgt = (addr_x < len_x) ? TGT_CODE0 : TGT_CODE1;
        end else if (addr_x >= RAM_LO && addr_x < RAM_HI) begin
            tgt = TGT_RAM;
        end else begin
            tgt = TGT_OTHER;
        end
    end
endmodule

// File: rtl/crg_sector_lock.sv
module crg_sector_lock #(
    parameter int SECTORS = 64
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_clr,
    input  logic                       set_valid,
    input  logic [SECTORS-1:0]         set_mask,
    input  logic [$clog2(SECTORS)-1:0] idx,
    output logic                       hit
);
    logic [SECTORS-1:0] lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (soft_clr) begin
            lock_q <= '0;
        end else if (set_valid) begin
            lock_q <= lock_q | set_mask;
        end
    end

    assign hit = lock_q[idx];

    // R8
    lock_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_clr |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R8
    lock_soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (lock_q == '0));
endmodule

// File: rtl/crg_policy.sv
module crg_policy
    import crg_pkg::*;
(
    input  logic    src_r0,
    input  tgt_e    tgt,
    input  logic    in_nvm,
    input  logic    lock_hit,
    input  logic [1:0] kind,
    input  policy_t pol,
    output logic    grant
);
    logic is_wr;

    always_comb begin
        is_wr = (kind == KIND_WRITE);
        if (is_wr && in_nvm && lock_hit) begin
            grant = 1'b0;
        end else if (src_r0 || !is_wr) begin
            grant = 1'b1;
        end else begin
            unique case (tgt)
                TGT_CODE0: grant = pol.r1_code_rw;
                TGT_RAM:   grant = pol.r1_ram_rw;
                TGT_CODE1: grant = 1'b1;
                TGT_OTHER: grant = 1'b1;
                default:   grant = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/code_region_guard.sv
module code_region_guard
    import crg_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int SECTORS      = 64,
    parameter int SECTOR_BYTES = 256,
    parameter int RAM_BASE     = 32'h8000,
    parameter int RAM_BYTES    = 32'h2000
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               cfg_load,
    input  logic [ADDR_W-1:0]  cfg_len,
    input  logic               cfg_r1_code_rw,
    input  logic               cfg_r1_ram_rw,
    input  logic               cfg_hard_fault,
    input  logic               lock_set,
    input  logic [SECTORS-1:0] lock_mask,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_pc,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               fault_valid,
    output logic [ADDR_W-1:0]  fault_addr,
    output logic [1:0]         fault_kind
);
    localparam int SEC_IDX_W = $clog2(SECTORS);

    state_e              st_q, st_nx;
    logic [ADDR_W-1:0]   len_q;
    policy_t             pol_q;
    logic [ADDR_W-1:0]   acc_addr_q;
    logic [DATA_W-1:0]   acc_wdata_q;
    logic [1:0]          acc_kind_q;

    logic                dec_src_r0;
    tgt_e                dec_tgt;
    logic                dec_in_nvm;
    logic [SEC_IDX_W-1:0] dec_sec;
    logic                lock_hit;
    logic                grant;
    logic                accept;
    logic                acc_is_wr;

    assign accept    = req_valid && req_ready;
    assign acc_is_wr = (acc_kind_q == KIND_WRITE);

    crg_decode #(
        .ADDR_W      (ADDR_W),
        .SECTORS     (SECTORS),
        .SECTOR_BYTES(SECTOR_BYTES),
        .RAM_BASE    (RAM_BASE),
        .RAM_BYTES   (RAM_BYTES)
    ) u_decode (
        .len    (len_q),
        .pc     (req_pc),
        .addr   (req_addr),
        .src_r0 (dec_src_r0),
        .tgt    (dec_tgt),
        .in_nvm (dec_in_nvm),
        .sec_idx(dec_sec)
    );

    crg_sector_lock #(
        .SECTORS(SECTORS)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_rst),
        .set_valid(lock_set),
        .set_mask (lock_mask),
        .idx      (dec_sec),
        .hit      (lock_hit)
    );

    crg_policy u_policy (
        .src_r0  (dec_src_r0),
        .tgt     (dec_tgt),
        .in_nvm  (dec_in_nvm),
        .lock_hit(lock_hit),
        .kind    (req_kind),
        .pol     (pol_q),
        .grant   (grant)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_UNCFG;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_UNCFG: st_nx = cfg_load ? ST_IDLE : ST_UNCFG;
            ST_IDLE,
            ST_GRANT,
            ST_DENY: begin
                if (req_valid) begin
                    st_nx = grant ? ST_GRANT : ST_DENY;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_UNCFG;
        endcase
    end

    // one-time policy capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            pol_q <= '0;
        end else if (st_q == ST_UNCFG && cfg_load) begin
            len_q <= cfg_len;
            pol_q <= '{r1_code_rw: cfg_r1_code_rw,
                       r1_ram_rw:  cfg_r1_ram_rw,
                       hard:       cfg_hard_fault};
        end
    end

    // accepted access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr_q  <= '0;
            acc_wdata_q <= '0;
            acc_kind_q  <= '0;
        end else if (accept) begin
            acc_addr_q  <= req_addr;
            acc_wdata_q <= req_wdata;
            acc_kind_q  <= req_kind;
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        rsp_rdata   = '0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        fault_valid = 1'b0;
        unique case (st_q)
            ST_UNCFG: begin
                req_ready = 1'b0;
            end
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_GRANT: begin
                req_ready = 1'b1;
                rsp_valid = 1'b1;
                mem_en    = 1'b1;
                mem_we    = acc_is_wr;
                rsp_rdata = acc_is_wr ? '0 : mem_rdata;
            end
            ST_DENY: begin
                req_ready   = 1'b1;
                rsp_valid   = 1'b1;
                fault_valid = pol_q.hard;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign mem_addr   = acc_addr_q;
    assign mem_wdata  = acc_wdata_q;
    assign fault_addr = acc_addr_q;
    assign fault_kind = acc_kind_q;

    // R1
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    // R11
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    // R11
    no_rsp_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);

    // R9
    deny_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !mem_en) |-> (rsp_rdata == '0));

    // R10
    fault_only_on_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (rsp_valid && !mem_en));

    // R7
    locked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_kind == KIND_WRITE && dec_in_nvm && lock_hit) |=> !mem_en);

    // R2
    r0_full_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_src_r0 && !(req_kind == KIND_WRITE && dec_in_nvm && lock_hit))
        |=> mem_en);
endmodule

// File: tb/sim_code_region_guard.sv
module sim_code_region_guard;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_len = '0;
    logic          cfg_r1_code_rw = 1'b0;
    logic          cfg_r1_ram_rw = 1'b0;
    logic          cfg_hard_fault = 1'b0;
    logic          lock_set = 1'b0;
    logic [NS-1:0] lock_mask = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_pc = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          fault_valid;
    logic [AW-1:0] fault_addr;
    logic [1:0]    fault_kind;

    always #5 clk = ~clk;

    code_region_guard u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_load(cfg_load), .cfg_len(cfg_len),
        .cfg_r1_code_rw(cfg_r1_code_rw), .cfg_r1_ram_rw(cfg_r1_ram_rw),
        .cfg_hard_fault(cfg_hard_fault),
        .lock_set(lock_set), .lock_mask(lock_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_pc(req_pc), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_kind(fault_kind)
    );

    // memory behind the block and the model's shadow of it
    logic [DW-1:0] dut_mem [0:1023];
    logic [DW-1:0] ref_mem [0:1023];

    function automatic int slot(input logic [AW-1:0] a);
        return int'({a[15:13], a[6:0]});
    endfunction

    assign mem_rdata = dut_mem[slot(mem_addr)];

    always @(posedge clk) begin
        if (mem_en && mem_we) dut_mem[slot(mem_addr)] <= mem_wdata;
    end

    // reference model
    int unsigned tests = 0;
    int unsigned fails = 0;
    bit          m_cfg = 0;
    int          m_len = 0;
    bit          m_code = 0, m_ram = 0, m_hard = 0;
    bit [NS-1:0] m_lock = '0;
    bit          p_valid = 0, p_grant = 0, p_we = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_wdata = '0;
    logic [1:0]    p_kind = '0;
    string         p_tag = "R11";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_len = 0; m_code = 0; m_ram = 0; m_hard = 0;
            m_lock = '0; p_valid = 0; p_grant = 0;
        end else begin
            int  a, pc, sec;
            bit  src0, wr, nvm, locked;
            if (p_valid && p_grant && p_we) ref_mem[slot(p_addr)] = p_wdata;
            p_valid = req_valid && m_cfg;
            if (p_valid) begin
                a = int'(req_addr); pc = int'(req_pc);
                wr = (req_kind == 2'd1);
                nvm = a < 16384;
                sec = a / 256;
                locked = nvm && m_lock[sec];
                src0 = (pc < 16384) && (pc < m_len);
                if (wr && locked) begin p_grant = 0; p_tag = "R7"; end
                else if (src0) begin p_grant = 1; p_tag = "R2"; end
                else if (!wr) begin p_grant = 1; p_tag = "R3"; end
                else if (nvm && a < m_len) begin p_grant = m_code; p_tag = "R4"; end
                else if (a >= 32'h8000 && a < 32'hA000) begin p_grant = m_ram; p_tag = "R5"; end
                else begin p_grant = 1; p_tag = "R6"; end
                p_we = wr; p_addr = req_addr; p_wdata = req_wdata; p_kind = req_kind;
            end
            if (!m_cfg && cfg_load) begin
                m_cfg = 1; m_len = int'(cfg_len);
                m_code = cfg_r1_code_rw; m_ram = cfg_r1_ram_rw; m_hard = cfg_hard_fault;
            end
            if (soft_rst) m_lock = '0;
            else if (lock_set) m_lock = m_lock | lock_mask;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            chk("R1", "ready in reset", 32'(req_ready), 0);
            chk("R1", "rsp in reset", 32'(rsp_valid), 0);
            chk("R1", "mem_en in reset", 32'(mem_en), 0);
            chk("R1", "fault in reset", 32'(fault_valid), 0);
        end else begin
            chk(m_cfg ? "R12" : "R1", "ready", 32'(req_ready), 32'(m_cfg));
            chk("R11", "rsp_valid", 32'(rsp_valid), 32'(p_valid));
            chk(p_valid ? p_tag : "R11", "mem_en", 32'(mem_en), 32'(p_valid && p_grant));
            chk("R10", "fault_valid", 32'(fault_valid), 32'(p_valid && !p_grant && m_hard));
            if (p_valid && p_grant) begin
                chk("R11", "mem_we", 32'(mem_we), 32'(p_we));
                chk("R11", "mem_addr", 32'(mem_addr), 32'(p_addr));
                if (p_we) chk("R11", "mem_wdata", mem_wdata, p_wdata);
                chk("R11", "rdata", rsp_rdata, p_we ? 32'd0 : ref_mem[slot(p_addr)]);
            end
            if (p_valid && !p_grant) begin
                chk("R9", "deny rdata", rsp_rdata, 0);
                if (m_hard) begin
                    chk("R10", "fault_addr", 32'(fault_addr), 32'(p_addr));
                    chk("R10", "fault_kind", 32'(fault_kind), 32'(p_kind));
                end
            end
        end
    end

    // watchdog
    int unsigned cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic acc(input logic [1:0] k, input logic [AW-1:0] pc,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_kind = k; req_pc = pc; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic load(input logic [AW-1:0] len, input bit c, input bit r, input bit h);
        cfg_load = 1'b1; cfg_len = len; cfg_r1_code_rw = c; cfg_r1_ram_rw = r; cfg_hard_fault = h;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            dut_mem[i] = '0;
            ref_mem[i] = '0;
        end
        idle(2);
        hard_reset();
        // R1: no requests taken before the load
        acc(2'd0, 16'h0100, 16'h0800, 0);
        idle(2);

        // silent mode: region 0 below 0x1000
        load(16'h1000, 1'b0, 1'b1, 1'b0);
        // R12: a second load with a larger length must not take effect
        load(16'h2000, 1'b1, 1'b1, 1'b1);
        idle(1);
        // R12/R6: write at 0x1800 from region 1 is region 1 code
        acc(2'd1, 16'h2000, 16'h1800, 32'h1234_5678);
        acc(2'd0, 16'h2000, 16'h1800, 0);
        // R2: region 0 writes everything
        acc(2'd1, 16'h0100, 16'h0800, 32'hAAAA_0001);
        acc(2'd1, 16'h0100, 16'h8010, 32'hAAAA_0002);
        acc(2'd1, 16'h0100, 16'hC000, 32'hAAAA_0003);
        acc(2'd0, 16'h0100, 16'h8010, 0);
        // R4: region 1 may not write region 0 code; R9: memory unchanged
        acc(2'd1, 16'h2000, 16'h0800, 32'hDEAD_BEEF);
        acc(2'd0, 16'h2000, 16'h0800, 0);
        // R3: fetch from region 0 code by region 1
        acc(2'd2, 16'h2000, 16'h0800, 0);
        // R5: region 1 RAM write allowed here
        acc(2'd1, 16'h2000, 16'h8020, 32'h5555_0001);
        acc(2'd0, 16'h9000, 16'h8020, 0);
        // R6: region 1 to other space
        acc(2'd1, 16'h2000, 16'hC040, 32'h6666_0001);
        idle(1);
        // R7: protect sectors 3 and 40
        lock_mask = '0; lock_mask[3] = 1'b1; lock_mask[40] = 1'b1; lock_set = 1'b1;
        @(negedge clk);
        lock_set = 1'b0;
        acc(2'd1, 16'h0100, 16'h0310, 32'h7777_0001);
        acc(2'd0, 16'h0100, 16'h0310, 0);
        acc(2'd1, 16'h2000, 16'h2810, 32'h7777_0002);
        acc(2'd2, 16'h2000, 16'h2810, 0);
        // R8: a set of zeros clears nothing
        lock_mask = '0; lock_set = 1'b1;
        @(negedge clk);
        lock_set = 1'b0;
        acc(2'd1, 16'h0100, 16'h0320, 32'h7777_0003);
        // R8: soft reset wins over a same-cycle set
        lock_mask = '1; lock_set = 1'b1; soft_rst = 1'b1;
        @(negedge clk);
        lock_set = 1'b0; soft_rst = 1'b0;
        acc(2'd1, 16'h0100, 16'h0310, 32'h7777_0004);
        acc(2'd0, 16'h0100, 16'h0310, 0);
        acc(2'd1, 16'h2000, 16'h2810, 32'h7777_0005);
        idle(2);

        // hard mode, reversed policy bits
        hard_reset();
        load(16'h0800, 1'b1, 1'b0, 1'b1);
        // R4: now allowed
        acc(2'd1, 16'h1000, 16'h0400, 32'h8888_0001);
        // R5/R10: RAM write refused with a fault pulse
        acc(2'd1, 16'h1000, 16'h8030, 32'h8888_0002);
        acc(2'd1, 16'h1000, 16'h8034, 32'h8888_0003);
        acc(2'd0, 16'h1000, 16'h8030, 0);
        // R7/R10: locked sector fault
        lock_mask = '0; lock_mask[0] = 1'b1; lock_set = 1'b1;
        @(negedge clk);
        lock_set = 1'b0;
        acc(2'd1, 16'h0010, 16'h0020, 32'h8888_0004);
        acc(2'd0, 16'h0010, 16'h0020, 0);
        idle(1);

        // mixed traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] pcs [4];
            logic [AW-1:0] ads [6];
            pcs = '{16'h0010, 16'h07F0, 16'h0800, 16'h8100};
            ads = '{16'h0020, 16'h07FC, 16'h3F00, 16'h8004, 16'h9FFC, 16'hF000};
            if ($urandom_range(0, 19) == 0) begin
                lock_mask = {$urandom, $urandom} & {$urandom, $urandom};
                lock_set = 1'b1;
            end
            soft_rst = ($urandom_range(0, 49) == 0);
            req_valid = ($urandom_range(0, 3) != 0);
            req_kind = 2'($urandom_range(0, 2));
            req_pc = pcs[$urandom_range(0, 3)];
            req_addr = ads[$urandom_range(0, 5)] + 16'($urandom_range(0, 3) * 4);
            req_wdata = $urandom;
            @(negedge clk);
            lock_set = 1'b0; soft_rst = 1'b0;
        end
        req_valid = 1'b0;
        idle(3);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule